// File: doc/BRIEF.md
# Buffered Dual-Mode Output Compare

This block sits next to one or two free-running 12-bit up-counters and watches them for programmed compare values. It has four compare channels. Each channel keeps a software-facing preload value and a separate active value; only the active value takes part in comparison. Software loads a channel's preload in two byte-wide writes, the upper nibble first. It then arms the channel's transfer bit. At the next overflow of the counter that owns the channel, the preload is copied into the active value and the transfer bit drops by itself.

A mode input selects how channels are routed to counters. In single-counter mode, counter 1 drives all four channels, both for comparison and for transfer timing. In dual-counter mode, channels 0 and 1 follow counter 1 and channels 2 and 3 follow counter 2. A channel whose counter first reaches its active value sets a sticky flag. Software clears the flag by writing a one to it. A shared interrupt line is high while any flag is set and the interrupt enable is on. An active value of zero never matches. Counter generation is outside this block.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, all flags, the interrupt output and all transfer-pending bits are 0, and every active compare value is 0.
- R2: A high write (`wr_hi_i`) stores `wr_data_i[3:0]` in a per-channel holding register. A later low write (`wr_lo_i`) sets the preload to {held nibble, `wr_data_i[7:0]`}. A high write alone leaves the preload unchanged.
- R3: An active value changes only in a cycle where the channel's governing overflow pulses while its transfer bit is pending. The copy clears the pending bit, and `xfer_pend_o[ch]` shows that bit.
- R4: The governing overflow is `ovf1_i` for channels 0 and 1 in both modes, and for all channels when `dual_mode_i`=0. When `dual_mode_i`=1, it is `ovf2_i` for channels 2 and 3.
- R5: Channels 0 and 1 compare against `cnt1_i`. Channels 2 and 3 compare against `cnt1_i` when `dual_mode_i`=0 and against `cnt2_i` when `dual_mode_i`=1.
- R6: An active value of 0 never sets a flag, even when the counter is 0.
- R7: When the routed counter becomes equal to a nonzero active value, `flag_o[ch]` is 1 after the next clock edge. While the counter stays at that value, the flag is not set again.
- R8: Pulsing `flag_clr_i[ch]` clears the flag. When a new match and a clear fall in the same cycle, the flag stays set.
- R9: `irq_o` equals `irq_en_i` AND (OR of all flags).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt1_i | input | 12 | Counter 1 value |
| cnt2_i | input | 12 | Counter 2 value |
| ovf1_i | input | 1 | Counter 1 overflow pulse |
| ovf2_i | input | 1 | Counter 2 overflow pulse |
| dual_mode_i | input | 1 | 1 selects dual-counter routing |
| wr_ch_i | input | 2 | Channel addressed by a write |
| wr_hi_i | input | 1 | High-part write strobe |
| wr_lo_i | input | 1 | Low-part write strobe, commits the preload |
| wr_data_i | input | 8 | Write data |
| xfer_set_i | input | 4 | Per-channel pulse that arms the transfer |
| flag_clr_i | input | 4 | Per-channel write-one-to-clear of the flags |
| irq_en_i | input | 1 | Compare interrupt enable |
| xfer_pend_o | output | 4 | Transfer-pending bits |
| flag_o | output | 4 | Compare flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. A new match can arrive together with a software clear of the same flag. An arming pulse can arrive together with the overflow that consumes an earlier arming. For the first pair, the bench moves the counter onto the compare value in the same cycle that it pulses the clear, and expects the flag to remain set. It also parks the counter on the compare value after a clear and expects no second set. Routing is judged by driving the two counters to different values, so that a match on the wrong counter, or a transfer on the wrong overflow, shows up at the flags and the pending bits.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned OC_CH    = 4;
  localparam int unsigned OC_CNT_W = 12;
  localparam int unsigned OC_LO_W  = 8;

  // upper half of the channels moves to counter 2 in dual mode
  function automatic logic use_cnt2(input int unsigned ch, input int unsigned half,
                                    input logic dual);
    return dual && (ch >= half);
  endfunction
endpackage

// File: rtl/ocmp_chan_buf.sv
module ocmp_chan_buf #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned LO_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [LO_W-1:0]  wr_data_i,
  input  logic             xfer_set_i,
  input  logic             ovf_i,
  output logic             pend_o,
  output logic [CNT_W-1:0] act_o
);
  localparam int unsigned HI_W = CNT_W - LO_W;

  logic [HI_W-1:0]  hold_q;
  logic [CNT_W-1:0] pre_q, act_q;
  logic             pend_q;
  logic             do_xfer;

  assign do_xfer = ovf_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pre_q  <= '0;
    end else begin
      if (wr_hi_i) hold_q <= wr_data_i[HI_W-1:0];
      if (wr_lo_i) pre_q  <= {hold_q, wr_data_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (do_xfer) act_q <= pre_q;
      pend_q <= (pend_q && !ovf_i) || xfer_set_i;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  p_xfer_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && pend_q && !xfer_set_i) |=> !pend_q);
  p_act_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_i && pend_q) |=> $stable(act_q));
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] act_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic hit, hit_q, evt, flag_q;

  assign hit = (cnt_i == act_i) && (act_i != '0);
  assign evt = hit && !hit_q;  // one event per arrival at the value

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (evt)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_zero_nomatch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0 && !flag_q) |=> !flag_q);
  p_stall_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_q && !flag_q && cnt_i == act_i) |=> !flag_q);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && act_i != '0 && cnt_i == act_i && !hit_q) |=> flag_q);
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int unsigned CNT_W  = OC_CNT_W,
  parameter int unsigned NUM_CH = OC_CH,
  parameter int unsigned LO_W   = OC_LO_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          cnt1_i,
  input  logic [CNT_W-1:0]          cnt2_i,
  input  logic                      ovf1_i,
  input  logic                      ovf2_i,
  input  logic                      dual_mode_i,
  input  logic [$clog2(NUM_CH)-1:0] wr_ch_i,
  input  logic                      wr_hi_i,
  input  logic                      wr_lo_i,
  input  logic [LO_W-1:0]           wr_data_i,
  input  logic [NUM_CH-1:0]         xfer_set_i,
  input  logic [NUM_CH-1:0]         flag_clr_i,
  input  logic                      irq_en_i,
  output logic [NUM_CH-1:0]         xfer_pend_o,
  output logic [NUM_CH-1:0]         flag_o,
  output logic                      irq_o
);
  localparam int unsigned SEL_W = $clog2(NUM_CH);
  localparam int unsigned HALF  = NUM_CH / 2;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             sel2, ovf_g, wsel;
    logic [CNT_W-1:0] cnt_g, act_g;

    assign sel2  = use_cnt2(g, HALF, dual_mode_i);
    assign ovf_g = sel2 ? ovf2_i : ovf1_i;
    assign cnt_g = sel2 ? cnt2_i : cnt1_i;
    assign wsel  = (wr_ch_i == SEL_W'(g));

    ocmp_chan_buf #(.CNT_W(CNT_W), .LO_W(LO_W)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hi_i    (wr_hi_i && wsel),
      .wr_lo_i    (wr_lo_i && wsel),
      .wr_data_i  (wr_data_i),
      .xfer_set_i (xfer_set_i[g]),
      .ovf_i      (ovf_g),
      .pend_o     (xfer_pend_o[g]),
      .act_o      (act_g)
    );

    ocmp_match #(.CNT_W(CNT_W)) u_match (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt_g),
      .act_i  (act_g),
      .clr_i  (flag_clr_i[g]),
      .flag_o (flag_o[g])
    );
  end

  assign irq_o = irq_en_i && (|flag_o);
endmodule

// File: tb/ocmp_unit_tb.sv
module ocmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] cnt1 = '0, cnt2 = '0;
  logic        ovf1 = 1'b0, ovf2 = 1'b0, dual = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  xset = '0, fclr = '0;
  logic        irq_en = 1'b0;
  logic [3:0]  pend, flag;
  logic        irq;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  ocmp_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt1_i(cnt1), .cnt2_i(cnt2),
    .ovf1_i(ovf1), .ovf2_i(ovf2), .dual_mode_i(dual), .wr_ch_i(wr_ch),
    .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wr_data_i(wr_data),
    .xfer_set_i(xset), .flag_clr_i(fclr), .irq_en_i(irq_en),
    .xfer_pend_o(pend), .flag_o(flag), .irq_o(irq)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_val(input logic [1:0] ch, input logic [11:0] v);
    wr_ch = ch; wr_hi = 1'b1; wr_data = {4'h0, v[11:8]}; step();
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0]; step();
    wr_lo = 1'b0;
  endtask

  task automatic arm(input logic [3:0] m);
    xset = m; step(); xset = '0;
  endtask

  task automatic pulse_ovf(input int which);
    if (which == 1) ovf1 = 1'b1; else ovf2 = 1'b1;
    step(); ovf1 = 1'b0; ovf2 = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    cnt1 = '0; cnt2 = '0; step();
    fclr = m; step(); fclr = '0;
  endtask

  task automatic t_reset();
    chk("R1 flags", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pend", pend, 0);
    irq_en = 1'b1; cnt1 = '0; cnt2 = '0; step(2);
    chk("R6 zero active never matches", flag, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_transfer();
    wr_val(0, 12'h123);
    pulse_ovf(1);
    cnt1 = 12'h123; step();
    chk("R3 no copy without pending bit", flag[0], 0);
    cnt1 = '0; arm(4'b0001);
    chk("R3 pending armed", pend[0], 1);
    pulse_ovf(1);
    chk("R3 pending self-clears", pend[0], 0);
    cnt1 = 12'h123; step();
    chk("R7 flag on match", flag[0], 1);
    irq_en = 1'b0; #1;
    chk("R9 irq masked", irq, 0);
    irq_en = 1'b1; #1;
    chk("R9 irq raised", irq, 1);
  endtask

  task automatic t_stall();
    fclr = 4'b0001; step(); fclr = '0;
    chk("R8 clear", flag[0], 0);
    step(3);
    chk("R7 no re-set while counter parked", flag[0], 0);
    chk("R9 irq low with no flag", irq, 0);
  endtask

  task automatic t_collision();
    cnt1 = '0; step();
    cnt1 = 12'h123; fclr = 4'b0001; step(); fclr = '0;
    chk("R8 set wins over clear", flag[0], 1);
    clear(4'b0001);
    chk("R8 cleared", flag[0], 0);
  endtask

  task automatic t_half();
    wr_val(1, 12'h0AB);
    wr_ch = 2'd1; wr_hi = 1'b1; wr_data = 8'h0F; step(); wr_hi = 1'b0;
    arm(4'b0010); pulse_ovf(1);
    cnt1 = 12'hFAB; step();
    chk("R2 lone high write not in preload", flag[1], 0);
    cnt1 = 12'h0AB; step();
    chk("R2 committed preload used", flag[1], 1);
    clear(4'b0010);
  endtask

  task automatic t_mode();
    wr_val(2, 12'h200); arm(4'b0100); pulse_ovf(1);
    cnt1 = 12'h200; step();
    chk("R5 single: ch2 on counter 1", flag[2], 1);
    clear(4'b0100);
    dual = 1'b1; cnt1 = 12'h200; step(2);
    chk("R5 dual: ch2 ignores counter 1", flag[2], 0);
    cnt2 = 12'h200; step();
    chk("R5 dual: ch2 on counter 2", flag[2], 1);
    clear(4'b0100);
    cnt2 = 12'h123; step(2);
    chk("R5 dual: ch0 ignores counter 2", flag[0], 0);
    cnt2 = '0;
  endtask

  task automatic t_route();
    wr_val(3, 12'h345); arm(4'b1000);
    pulse_ovf(1);
    chk("R4 dual: ch3 waits for counter 2 overflow", pend[3], 1);
    pulse_ovf(2);
    chk("R4 dual: ch3 taken on counter 2 overflow", pend[3], 0);
    cnt2 = 12'h345; step();
    chk("R4 ch3 new value active", flag[3], 1);
    clear(4'b1000);
    wr_val(0, 12'h050); arm(4'b0001);
    pulse_ovf(2);
    chk("R4 dual: ch0 ignores counter 2 overflow", pend[0], 1);
    pulse_ovf(1);
    chk("R4 dual: ch0 taken on counter 1 overflow", pend[0], 0);
    cnt1 = 12'h050; step();
    chk("R4 ch0 new value active", flag[0], 1);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_transfer();
    t_stall();
    t_collision();
    t_half();
    t_mode();
    t_route();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule